// File: doc/BRIEF.md
# Flash Command Mailbox Controller

This block lets a processor erase, program and read back a two-block on-chip program store through six byte-wide registers. The store is a behavioural array: a primary block and a smaller secondary block, both split into fixed-size sectors. Software sets the target address in two address-byte registers and puts program data in the data register. It then writes an operation code into the command register. The controller latches the job, holds a busy flag for a set number of cycles, then changes or reads the array in the cycle that busy drops.

A command is taken only while the enable bit of the configuration register is set and no job is running. The top bit of each command selects how completion is reported: a one-cycle interrupt pulse, or polling of the busy bit in the status register. Each block has a write-protect input. A protected block keeps its contents through erase and program jobs, but those jobs still run their full time. A byte can be programmed only while it still holds the erased value.

Top module: `flash_mbox_ctrl`

## Requirements
- R1: After reset, busy_o and irq_o are 0 and the command, data, address and configuration registers read 0. Every array byte reads 8'hFF.
- R2: Register index 4 is the configuration register and it reads back what was written. While its bit 6 is 0, a write to the command register (index 0) is ignored and busy stays 0.
- R3: Command bits [3:0] select the operation: 4'h1 block erase, 4'h3 sector erase, 4'hC verify, 4'hE program. Any other code is ignored. Register index 0 reads back the last accepted command byte.
- R4: An accepted command raises busy_o in the next cycle. busy_o stays high for ERASE_CYC cycles for an erase, PROG_CYC cycles for a program and VERIFY_CYC cycles for a verify. Status register (index 5) bit 0 mirrors busy_o.
- R5: When command bit 7 is 1, irq_o is high for exactly the one cycle in which busy_o has just fallen. When bit 7 is 0, irq_o stays 0.
- R6: A command write is discarded while busy_o is 1, including the cycle in which the running job completes.
- R7: The target address is {high byte (index 3), low byte (index 2)}. Bit 15 set selects the secondary block. The byte offset is the address modulo the selected block's size. Address and data are captured when the command is accepted, so later register writes do not affect the running job.
- R8: Program (data from index 1) changes a byte only if it reads 8'hFF, and then the byte becomes the data value. Any other byte keeps its value.
- R9: Verify loads the addressed byte into the data register (index 1) on completion. If the processor writes the data register in that same cycle, the verify result wins.
- R10: Sector erase sets to 8'hFF only the SECTOR-byte aligned sector that holds the target offset.
- R11: Block erase sets every byte of the selected block to 8'hFF and leaves the other block unchanged.
- R12: block_lock_i[0] protects the primary block and block_lock_i[1] protects the secondary block. The lock is sampled when the command is accepted. A protected block is left unchanged by erase and program, while busy and the interrupt behave as usual.
- R13: Status register bits [7:5] show sec_bits_i, and bits [4:1] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 command, 1 data, 2 address low, 3 address high, 4 configuration, 5 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the register selected by reg_addr_i |
| block_lock_i | input | 2 | Write protection: bit 0 primary block, bit 1 secondary block |
| sec_bits_i | input | 3 | Security bits shown in the status register |
| busy_o | output | 1 | An operation is in progress |
| irq_o | output | 1 | Completion pulse for commands that asked for an interrupt |

## Verification
Two clashes can fall in the same cycle: a new command written on the edge where the running job completes, and a processor write to the data register on the edge where a verify stores its result. The bench times both writes to the exact completion edge by counting cycles from acceptance. In the first case it judges by showing that busy stays low afterwards and that a follow-up verify finds the array untouched. In the second it reads back the data register and expects the array byte, not the written value. A cycle-level reference model of registers, busy, interrupt and array contents is compared against the outputs on every clock.

// File: rtl/flash_mbox_pkg.sv
package flash_mbox_pkg;
  localparam logic [2:0] RA_CMD     = 3'd0;
  localparam logic [2:0] RA_DATA    = 3'd1;
  localparam logic [2:0] RA_ADDR_LO = 3'd2;
  localparam logic [2:0] RA_ADDR_HI = 3'd3;
  localparam logic [2:0] RA_CFG     = 3'd4;
  localparam logic [2:0] RA_STATUS  = 3'd5;

  localparam int CFG_EN_BIT  = 6;
  localparam int CMD_IRQ_BIT = 7;

  typedef enum logic [3:0] {
    OP_BLK_ERASE = 4'h1,
    OP_SEC_ERASE = 4'h3,
    OP_VERIFY    = 4'hC,
    OP_PROGRAM   = 4'hE
  } op_e;

  function automatic logic op_valid(logic [3:0] code);
    return (code == OP_BLK_ERASE) || (code == OP_SEC_ERASE) ||
           (code == OP_VERIFY)    || (code == OP_PROGRAM);
  endfunction
endpackage

// File: rtl/flash_bank.sv
module flash_bank
  import flash_mbox_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int SECTOR = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  op_e           op_i,
  input  logic [AW-1:0] off_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  assign rdata_o = mem_q[off_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en_i) begin
      unique case (op_i)
        OP_PROGRAM: begin
          if (mem_q[off_i] == 8'hFF) mem_q[off_i] <= mem_q[off_i] & wdata_i;
        end
        OP_SEC_ERASE: begin
          for (int i = 0; i < DEPTH; i++)
            if (i / SECTOR == int'(off_i) / SECTOR) mem_q[i] <= 8'hFF;
        end
        OP_BLK_ERASE: begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_mbox_regs.sv
module flash_mbox_regs
  import flash_mbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        busy_i,
  input  logic        vdone_i,
  input  logic [7:0]  vdata_i,
  input  logic [2:0]  sec_bits_i,
  output logic        start_o,
  output logic [7:0]  cmd_o,
  output logic [15:0] addr_o,
  output logic [7:0]  data_o,
  output logic        cfg_en_o,
  output logic [7:0]  rdata_o
);
  logic [7:0] cmd_q, data_q, lo_q, hi_q, cfg_q;
  logic       wr_cmd;

  assign wr_cmd   = reg_we_i && (reg_addr_i == RA_CMD);
  assign cfg_en_o = cfg_q[CFG_EN_BIT];
  assign start_o  = wr_cmd && cfg_en_o && !busy_i && op_valid(reg_wdata_i[3:0]);
  assign cmd_o    = reg_wdata_i;
  assign addr_o   = {hi_q, lo_q};
  assign data_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      cfg_q  <= '0;
    end else begin
      if (start_o) cmd_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_ADDR_LO) lo_q  <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_ADDR_HI) hi_q  <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_CFG)     cfg_q <= reg_wdata_i;
      // verify result has priority over a same-cycle CPU write
      if (vdone_i) data_q <= vdata_i;
      else if (reg_we_i && reg_addr_i == RA_DATA) data_q <= reg_wdata_i;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_CMD:     rdata_o = cmd_q;
      RA_DATA:    rdata_o = data_q;
      RA_ADDR_LO: rdata_o = lo_q;
      RA_ADDR_HI: rdata_o = hi_q;
      RA_CFG:     rdata_o = cfg_q;
      RA_STATUS:  rdata_o = {sec_bits_i, 4'b0000, busy_i};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_mbox_seq.sv
module flash_mbox_seq
  import flash_mbox_pkg::*;
#(
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 6,
  parameter int VERIFY_CYC = 2,
  localparam int MAX_A     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int MAX_CYC   = (MAX_A > VERIFY_CYC) ? MAX_A : VERIFY_CYC,
  localparam int CW        = $clog2(MAX_CYC + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  cmd_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic [1:0]  lock_i,
  output logic        busy_o,
  output logic        irq_o,
  output logic        fire_o,
  output op_e         op_o,
  output logic [15:0] addr_o,
  output logic [7:0]  data_o,
  output logic        locked_o
);
  logic          busy_q, irq_q, ien_q, lock_q;
  logic [CW-1:0] cnt_q, load_cnt;
  op_e           op_q;
  logic [15:0]   addr_q;
  logic [7:0]    data_q;

  always_comb begin
    unique case (cmd_i[3:0])
      OP_BLK_ERASE, OP_SEC_ERASE: load_cnt = CW'(ERASE_CYC - 1);
      OP_PROGRAM:                 load_cnt = CW'(PROG_CYC - 1);
      default:                    load_cnt = CW'(VERIFY_CYC - 1);
    endcase
  end

  assign fire_o   = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign irq_o    = irq_q;
  assign op_o     = op_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign locked_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      ien_q  <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_VERIFY;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      irq_q <= fire_o && ien_q;
      if (fire_o)      busy_q <= 1'b0;
      else if (busy_q) cnt_q  <= cnt_q - 1'b1;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= load_cnt;
        op_q   <= op_e'(cmd_i[3:0]);
        ien_q  <= cmd_i[CMD_IRQ_BIT];
        addr_q <= addr_i;
        data_q <= data_i;
        lock_q <= lock_i[addr_i[15]];
      end
    end
  end
endmodule

// File: rtl/flash_mbox_ctrl.sv
module flash_mbox_ctrl
  import flash_mbox_pkg::*;
#(
  parameter int PRI_BYTES  = 1024,
  parameter int SEC_BYTES  = 512,
  parameter int SECTOR     = 128,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 6,
  parameter int VERIFY_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [1:0] block_lock_i,
  input  logic [2:0] sec_bits_i,
  output logic       busy_o,
  output logic       irq_o
);
  logic        start, fire, locked, cfg_en, vdone;
  logic [7:0]  cmd, reg_data, job_data, vdata;
  logic [15:0] reg_addr, job_addr;
  op_e         job_op;
  logic [7:0]  bank_rd [2];
  logic        addr_unused;

  assign addr_unused = ^job_addr;

  flash_mbox_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .busy_i     (busy_o),
    .vdone_i    (vdone),
    .vdata_i    (vdata),
    .sec_bits_i (sec_bits_i),
    .start_o    (start),
    .cmd_o      (cmd),
    .addr_o     (reg_addr),
    .data_o     (reg_data),
    .cfg_en_o   (cfg_en),
    .rdata_o    (reg_rdata_o)
  );

  flash_mbox_seq #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .VERIFY_CYC(VERIFY_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cmd_i   (cmd),
    .addr_i  (reg_addr),
    .data_i  (reg_data),
    .lock_i  (block_lock_i),
    .busy_o  (busy_o),
    .irq_o   (irq_o),
    .fire_o  (fire),
    .op_o    (job_op),
    .addr_o  (job_addr),
    .data_o  (job_data),
    .locked_o(locked)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int DEPTH = (b == 0) ? PRI_BYTES : SEC_BYTES;
    localparam int AW    = $clog2(DEPTH);
    logic wr_en;
    assign wr_en = fire && !locked && (job_addr[15] == 1'(b)) && (job_op != OP_VERIFY);
    flash_bank #(
      .DEPTH (DEPTH),
      .SECTOR(SECTOR)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en),
      .op_i   (job_op),
      .off_i  (job_addr[AW-1:0]),
      .wdata_i(job_data),
      .rdata_o(bank_rd[b])
    );
  end

  assign vdone = fire && (job_op == OP_VERIFY);
  assign vdata = bank_rd[job_addr[15]];
endmodule

// File: rtl/flash_mbox_chk.sv
module flash_mbox_chk
  import flash_mbox_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [2:0] reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic [2:0] sec_bits_i,
  input logic       busy_o,
  input logic       irq_o,
  input logic       cfg_en
);
  a_r4_rise_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i && reg_addr_i == RA_CMD));

  a_r2_disabled_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_CMD && !cfg_en && !busy_o) |=> !busy_o);

  a_r5_irq_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $fell(busy_o));

  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r4_status_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_STATUS) |-> (reg_rdata_o[0] == busy_o));

  a_r13_status_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_STATUS) |-> (reg_rdata_o[7:5] == sec_bits_i && reg_rdata_o[4:1] == 4'b0));
endmodule

bind flash_mbox_ctrl flash_mbox_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .sec_bits_i (sec_bits_i),
  .busy_o     (busy_o),
  .irq_o      (irq_o),
  .cfg_en     (cfg_en)
);

// File: tb/flash_mbox_ctrl_tb_top.sv
module flash_mbox_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRI  = 1024;
  localparam int SEC  = 512;
  localparam int SECT = 128;
  localparam int ERC  = 20;
  localparam int PGC  = 6;
  localparam int VFC  = 2;

  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] ra = 3'd0;
  logic [7:0] wd = 8'd0;
  logic [1:0] lk = 2'b00;
  logic [2:0] sb = 3'b101;
  logic [7:0] rdata;
  logic       busy, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mbox_ctrl #(
    .PRI_BYTES(PRI), .SEC_BYTES(SEC), .SECTOR(SECT),
    .ERASE_CYC(ERC), .PROG_CYC(PGC), .VERIFY_CYC(VFC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .block_lock_i(lk),
    .sec_bits_i(sb), .busy_o(busy), .irq_o(irq)
  );

  // reference model
  logic [7:0]  pm [PRI];
  logic [7:0]  sm [SEC];
  logic [7:0]  m_cmd, m_data, m_lo, m_hi, m_cfg;
  logic        m_busy, m_irq, m_ien, m_lock;
  int          m_cnt;
  logic [3:0]  m_op;
  logic [15:0] m_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_cmd;
      3'd1: return m_data;
      3'd2: return m_lo;
      3'd3: return m_hi;
      3'd4: return m_cfg;
      3'd5: return {sb, 4'b0000, m_busy};
      default: return 8'h00;
    endcase
  endfunction

  function automatic int dur(logic [3:0] c);
    if (c == 4'h1 || c == 4'h3) return ERC;
    if (c == 4'hE) return PGC;
    return VFC;
  endfunction

  task automatic model_apply();
    int off;
    if (m_addr[15]) off = int'(m_addr[14:0]) % SEC;
    else            off = int'(m_addr[14:0]) % PRI;
    if (m_op == 4'hC) begin
      m_data = m_addr[15] ? sm[off] : pm[off];
    end else if (!m_lock) begin
      if (m_op == 4'hE) begin
        if (m_addr[15]) begin if (sm[off] == 8'hFF) sm[off] = m_data_job; end
        else begin if (pm[off] == 8'hFF) pm[off] = m_data_job; end
      end else begin
        for (int i = 0; i < (m_addr[15] ? SEC : PRI); i++)
          if (m_op == 4'h1 || (i / SECT == off / SECT)) begin
            if (m_addr[15]) sm[i] = 8'hFF; else pm[i] = 8'hFF;
          end
      end
    end
  endtask

  logic [7:0] m_data_job;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRI; i++) pm[i] = 8'hFF;
      for (int i = 0; i < SEC; i++) sm[i] = 8'hFF;
      m_cmd = 0; m_data = 0; m_lo = 0; m_hi = 0; m_cfg = 0;
      m_busy = 0; m_irq = 0; m_ien = 0; m_lock = 0; m_cnt = 0;
      m_op = 4'hC; m_addr = 0; m_data_job = 0;
    end else begin
      bit was_busy, en, fin;
      was_busy = m_busy;
      en = m_cfg[6];
      fin = 1'b0;
      m_irq = 1'b0;
      if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 0; m_irq = m_ien; fin = 1'b1; end
        else m_cnt--;
      end
      if (we) begin
        case (ra)
          3'd1: m_data = wd;
          3'd2: m_lo = wd;
          3'd3: m_hi = wd;
          3'd4: m_cfg = wd;
          default: ;
        endcase
      end
      if (fin) model_apply();
      if (we && ra == 3'd0 && en && !was_busy &&
          (wd[3:0] == 4'h1 || wd[3:0] == 4'h3 || wd[3:0] == 4'hC || wd[3:0] == 4'hE)) begin
        m_cmd = wd; m_op = wd[3:0]; m_ien = wd[7];
        m_addr = {m_hi, m_lo}; m_data_job = m_data;
        m_lock = lk[m_addr[15]];
        m_busy = 1; m_cnt = dur(wd[3:0]) - 1;
      end
    end
  end

  // one cycle: compare with the model, then drive the next inputs
  task automatic cyc(bit w, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    chk(busy === m_busy, "R4 busy", busy, m_busy);
    chk(irq === m_irq, "R5 irq", irq, m_irq);
    chk(rdata === exp_rd(ra), "R1/R13 readback", rdata, exp_rd(ra));
    we = w; ra = a; wd = d;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d); cyc(1'b1, a, d); endtask
  task automatic idle(logic [2:0] a); cyc(1'b0, a, 8'h00); endtask

  task automatic run(logic [7:0] c, logic [7:0] hi, logic [7:0] lo,
                     output int nbusy, output int nirq);
    nbusy = 0; nirq = 0;
    wr(3'd2, lo); wr(3'd3, hi); wr(3'd0, c);
    do begin
      idle(3'd5);
      if (busy === 1'b1) nbusy++;
      if (irq === 1'b1) nirq++;
    end while (m_busy);
    idle(3'd5);
    if (irq === 1'b1) nirq++;
  endtask

  task automatic expect_rd(logic [2:0] a, logic [7:0] exp, string req);
    idle(a);
    @(posedge clk); #1;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic verify_at(logic [7:0] hi, logic [7:0] lo, logic [7:0] exp, string req);
    int nb, ni;
    run(8'h0C, hi, lo, nb, ni);
    expect_rd(3'd1, exp, req);
  endtask

  initial begin
    int nb, ni;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(busy === 1'b0 && irq === 1'b0, "R1 outputs", {busy, irq}, 0);
    expect_rd(3'd0, 8'h00, "R1 cmd");
    expect_rd(3'd1, 8'h00, "R1 data");
    expect_rd(3'd4, 8'h00, "R1 cfg");
    expect_rd(3'd5, {sb, 5'b0}, "R13 status after reset");

    // R2 disabled interface
    wr(3'd0, 8'h0C);
    expect_rd(3'd5, {sb, 5'b0}, "R2 cmd ignored when disabled");
    wr(3'd4, 8'h40);
    expect_rd(3'd4, 8'h40, "R2 cfg readback");

    // R1 erased array
    verify_at(8'h01, 8'h23, 8'hFF, "R1 array erased");
    expect_rd(3'd0, 8'h0C, "R3 cmd readback");

    // R3 invalid code
    wr(3'd0, 8'h07);
    expect_rd(3'd5, {sb, 5'b0}, "R3 invalid code no busy");
    expect_rd(3'd0, 8'h0C, "R3 invalid not recorded");

    // R8 program with interrupt
    wr(3'd1, 8'h5A);
    run(8'h8E, 8'h00, 8'h10, nb, ni);
    chk(nb == PGC, "R4 program duration", nb, PGC);
    chk(ni == 1, "R5 one irq pulse", ni, 1);
    verify_at(8'h00, 8'h10, 8'h5A, "R8 programmed byte");

    // R8 reprogram refused; R5 no irq for polling
    wr(3'd1, 8'h00);
    run(8'h0E, 8'h00, 8'h10, nb, ni);
    chk(ni == 0, "R5 polling gives no irq", ni, 0);
    verify_at(8'h00, 8'h10, 8'h5A, "R8 non-erased byte kept");

    // R7 secondary block and offset folding
    wr(3'd1, 8'h33);
    run(8'h0E, 8'h80, 8'h05, nb, ni);
    verify_at(8'h00, 8'h05, 8'hFF, "R7 primary untouched");
    verify_at(8'h82, 8'h05, 8'h33, "R7 secondary offset modulo size");

    // R7 snapshot at accept
    wr(3'd2, 8'h20); wr(3'd3, 8'h00); wr(3'd1, 8'h11); wr(3'd0, 8'h0E);
    wr(3'd2, 8'h30); wr(3'd1, 8'h22);
    do idle(3'd5); while (m_busy);
    verify_at(8'h00, 8'h20, 8'h11, "R7 captured address and data");
    verify_at(8'h00, 8'h30, 8'hFF, "R7 later address not used");

    // R12 lock on primary
    wr(3'd1, 8'hA5);
    run(8'h0E, 8'h00, 8'h90, nb, ni);
    lk = 2'b01;
    run(8'h83, 8'h00, 8'h10, nb, ni);
    chk(nb == ERC, "R4 erase duration", nb, ERC);
    chk(ni == 1, "R12 irq still on locked block", ni, 1);
    run(8'h01, 8'h00, 8'h00, nb, ni);
    wr(3'd1, 8'h00);
    run(8'h0E, 8'h00, 8'h40, nb, ni);
    lk = 2'b00;
    verify_at(8'h00, 8'h10, 8'h5A, "R12 locked erase no change");
    verify_at(8'h00, 8'h40, 8'hFF, "R12 locked program no change");

    // R10 sector erase
    run(8'h03, 8'h00, 8'h10, nb, ni);
    verify_at(8'h00, 8'h10, 8'hFF, "R10 sector erased");
    verify_at(8'h00, 8'h20, 8'hFF, "R10 same sector erased");
    verify_at(8'h00, 8'h90, 8'hA5, "R10 next sector kept");

    // R11 block erase of secondary
    run(8'h01, 8'h80, 8'h00, nb, ni);
    verify_at(8'h80, 8'h05, 8'hFF, "R11 secondary erased");
    verify_at(8'h00, 8'h90, 8'hA5, "R11 primary kept");

    // R6 commands while busy and on completion edge
    wr(3'd1, 8'h0F); wr(3'd2, 8'h50); wr(3'd3, 8'h00);
    wr(3'd0, 8'h0E);
    idle(3'd5);
    wr(3'd0, 8'h81);
    repeat (PGC - 3) idle(3'd5);
    wr(3'd0, 8'h0C);
    idle(3'd5);
    @(posedge clk); #1;
    chk(busy === 1'b0, "R6 completion-edge command dropped", busy, 0);
    verify_at(8'h00, 8'h50, 8'h0F, "R6 program done");
    verify_at(8'h00, 8'h90, 8'hA5, "R6 mid-busy erase dropped");

    // R9 verify result versus same-cycle data write
    wr(3'd2, 8'h90); wr(3'd3, 8'h00);
    wr(3'd0, 8'h0C);
    idle(3'd5);
    wr(3'd1, 8'h77);
    expect_rd(3'd1, 8'hA5, "R9 verify result wins");

    // R13 security bits
    sb = 3'b010;
    expect_rd(3'd5, 8'h40, "R13 status bits");
    idle(3'd5);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule